// File: doc/BRIEF.md
# Enhanced Register Window Decoder

This block sits behind a 64 KB memory window of a graphics controller and turns byte, word and dword requests into accesses to the right target. Offsets in the lower half are the pixel-transfer port that feeds the drawing engine. Offsets in the upper half reach register targets: a small accelerator register stub, a mirror of the legacy VGA I/O ports, the subsystem control and status registers, the advanced function control register, and a bank of 32-bit overlay stream registers.

A mode input selects the decode. In legacy decode only address bit 15 matters: it chooses between register space and pixel data. In enhanced decode, fixed sub-ranges of the upper half map to the VGA ports, the subsystem registers and the stream bank. Word and dword accesses that do not hit a stream register are split into byte lanes in little-endian order. Every output is registered. A read returns its data one cycle after the request, together with a valid strobe.

Top module: `mmw_decoder`

## Requirements
- R1: After reset rd_valid, pix_start and irq are 0, adv_ctl is 0x00, and every stored register reads as zero.
- R2: A read request accepted on a clock edge raises rd_valid for exactly the following cycle, and rd_data holds its result then. Write requests never raise rd_valid.
- R3: A write to an offset below 0x8000, in either mode, with cpu_src high raises pix_start for one cycle after the edge. With cpu_src low no pulse is produced. Reads below 0x8000 return 0xFFFFFFFF.
- R4: pix_data carries the write data spread to 32 bits. A byte (req_size 0) is copied into all four lanes. A word (req_size 1) is copied into both halves. A dword (req_size 2) passes unchanged.
- R5: In enhanced mode, byte offsets 0x83B0 to 0x83DF reach VGA port stub registers, indexed by the low 10 offset bits, for both reads and writes.
- R6: In enhanced mode, a byte write to 0x8505 loads the subsystem control byte, and a byte write to 0x8504 has no effect. A read lane at 0x8504 returns status and one at 0x8505 returns control.
- R7: A dword write to 0x8504 in enhanced mode clears each status bit set in data[7:0] and loads control from data[15:8]. Status bits are set by stat_set, and a set wins over a clear in the same cycle.
- R8: irq is high exactly when some bit is set in both status and control. It follows a status or control change on the same edge.
- R9: In enhanced mode, a write lane at 0x850C loads adv_ctl from its byte. Reads of 0x850C return 0xFF in that lane.
- R10: In enhanced mode, dword accesses to 0x8180 to 0x81FC (address bits 1:0 ignored) reach 32-bit stream registers. Only slots set in STREAM_MASK store data. Unimplemented slots, and byte or word accesses in that range, read 0xFFFFFFFF and ignore writes.
- R11: In legacy mode, offsets with bit 15 set reach only the accelerator stub at 0x8000 to 0x800F, which both modes share. The VGA, subsystem and stream ranges are unmapped there.
- R12: Unmapped byte lanes read 0xFF. Lanes above the access size read 0xFF, so a byte read returns 0xFFFFFF in bits 31:8.
- R13: With accel_en low, every read returns 0xFFFFFFFF, every write is ignored and no pixel pulse is produced.
- R14: A word access uses base address (offset & ~1) and a dword access uses (offset & ~3). Lane i of the access covers byte base+i and sits in data bits 8i+7:8i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| accel_en | input | 1 | Window enable; when low, reads give all ones and writes are dropped |
| enh_mode | input | 1 | 1 selects enhanced decode, 0 selects legacy decode |
| cpu_src | input | 1 | Current drawing command takes its source from the CPU |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 1 word, 2 dword |
| req_addr | input | 16 | Offset within the window |
| req_wdata | input | 32 | Write data, little-endian lanes |
| stat_set | input | 8 | Status event bits to set |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| pix_start | output | 1 | One-cycle drawing-engine start pulse |
| pix_data | output | 32 | Spread pixel-transfer data |
| adv_ctl | output | 8 | Advanced function control register |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check the following relations. Each pixel pulse must come from an enabled write below 0x8000 with a CPU source. A byte pixel write must come out replicated four times. rd_valid must follow only a read. Disabled reads must return all ones, and disabled writes must leave adv_ctl untouched. irq must equal the OR of the status and control overlap. The bench scenarios cover the behaviours that depend on stored contents and address arithmetic. These are little-endian lane splitting and alignment, the write-one-to-clear with set priority, the ignored byte write at 0x8504, the unimplemented stream slots, and the ranges that disappear in legacy decode.

// File: rtl/mmw_pkg.sv
package mmw_pkg;
  localparam int NL = 4;  // byte lanes on the 32-bit data path

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_W = 2'd1, SZ_D = 2'd2} size_e;

  typedef enum logic [2:0] {
    TG_NONE, TG_VGA, TG_ACC, TG_SSTAT, TG_SCTL, TG_ADV
  } tgt_e;

  typedef struct packed {
    logic       act;
    tgt_e       tgt;
    logic [5:0] idx;
    logic [7:0] wd;
  } lane_t;

  // pixel data spread: byte -> x4, word -> x2, dword as is (R4)
  function automatic logic [31:0] spread(input logic [31:0] d, input logic [1:0] sz);
    case (sz)
      SZ_B:    spread = {4{d[7:0]}};
      SZ_W:    spread = {2{d[15:0]}};
      default: spread = d;
    endcase
  endfunction

  // aligned base byte address of a split access (R14)
  function automatic logic [15:0] align_base(input logic [15:0] a, input logic [1:0] sz);
    case (sz)
      SZ_B:    align_base = a;
      SZ_W:    align_base = {a[15:1], 1'b0};
      default: align_base = {a[15:2], 2'b00};
    endcase
  endfunction

  function automatic logic [NL-1:0] lane_mask(input logic [1:0] sz);
    case (sz)
      SZ_B:    lane_mask = 4'b0001;
      SZ_W:    lane_mask = 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/mmw_lane_dec.sv
module mmw_lane_dec
  import mmw_pkg::*;
#(
  parameter logic [9:0]  VGA_LO    = 10'h3B0,
  parameter logic [9:0]  VGA_HI    = 10'h3DF,
  parameter logic [15:0] ACC_BASE  = 16'h8000,
  parameter int          ACC_BYTES = 16
) (
  input  logic [15:0] baddr,
  input  logic        enh,
  output tgt_e        tgt,
  output logic [5:0]  idx
);
  localparam logic [15:0] ACC_END = ACC_BASE + 16'(ACC_BYTES);

  logic [9:0]  voff;
  logic [15:0] aoff;
  assign voff = baddr[9:0] - VGA_LO;
  assign aoff = baddr - ACC_BASE;

  always_comb begin
    tgt = TG_NONE;
    idx = '0;
    if (baddr >= ACC_BASE && baddr < ACC_END) begin
      tgt = TG_ACC;
      idx = aoff[5:0];
    end else if (enh) begin
      if (baddr[15:10] == 6'b100000 && baddr[9:0] >= VGA_LO && baddr[9:0] <= VGA_HI) begin
        tgt = TG_VGA;
        idx = voff[5:0];
      end else if (baddr == 16'h8504) tgt = TG_SSTAT;
      else if (baddr == 16'h8505) tgt = TG_SCTL;
      else if (baddr == 16'h850C) tgt = TG_ADV;
    end
  end
endmodule

// File: rtl/mmw_byte_regs.sv
module mmw_byte_regs
  import mmw_pkg::*;
#(
  parameter int VGA_N = 48,
  parameter int ACC_N = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  lane_t [NL-1:0]       lanes,
  input  logic                 lanes_we,
  input  logic                 w1c_en,
  input  logic [7:0]           w1c_mask,
  input  logic [7:0]           ctl_load,
  input  logic [7:0]           stat_set,
  output logic [NL-1:0][7:0]   lane_rd,
  output logic [7:0]           ctl_q,
  output logic [7:0]           stat_q,
  output logic [7:0]           adv_q,
  output logic                 irq_q
);
  localparam int ACC_AW = $clog2(ACC_N);

  logic [7:0] vga_q [VGA_N];
  logic [7:0] acc_q [ACC_N];
  logic [7:0] ctl_d, stat_d, adv_d;

  always_comb begin
    ctl_d = ctl_q;
    adv_d = adv_q;
    for (int i = 0; i < NL; i++) begin
      if (lanes_we && lanes[i].act) begin
        if (lanes[i].tgt == TG_SCTL) ctl_d = lanes[i].wd;
        if (lanes[i].tgt == TG_ADV)  adv_d = lanes[i].wd;
      end
    end
    if (w1c_en) ctl_d = ctl_load;
    stat_d = (stat_q & ~(w1c_en ? w1c_mask : 8'h00)) | stat_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < VGA_N; k++) vga_q[k] <= '0;
      for (int k = 0; k < ACC_N; k++) acc_q[k] <= '0;
      ctl_q  <= '0;
      stat_q <= '0;
      adv_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      for (int i = 0; i < NL; i++) begin
        if (lanes_we && lanes[i].act) begin
          if (lanes[i].tgt == TG_VGA) vga_q[lanes[i].idx] <= lanes[i].wd;
          if (lanes[i].tgt == TG_ACC) acc_q[lanes[i].idx[ACC_AW-1:0]] <= lanes[i].wd;
        end
      end
      ctl_q  <= ctl_d;
      stat_q <= stat_d;
      adv_q  <= adv_d;
      irq_q  <= |(stat_d & ctl_d);
    end
  end

  always_comb begin
    for (int i = 0; i < NL; i++) begin
      case (lanes[i].tgt)
        TG_VGA:   lane_rd[i] = vga_q[lanes[i].idx];
        TG_ACC:   lane_rd[i] = acc_q[lanes[i].idx[ACC_AW-1:0]];
        TG_SSTAT: lane_rd[i] = stat_q;
        TG_SCTL:  lane_rd[i] = ctl_q;
        default:  lane_rd[i] = 8'hFF;
      endcase
    end
  end
endmodule

// File: rtl/mmw_stream_bank.sv
module mmw_stream_bank #(
  parameter int          SLOTS = 32,
  parameter logic [31:0] MASK  = 32'hFFFF_0173,
  localparam int         SW    = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] slot,
  input  logic [31:0]   wd,
  output logic [31:0]   rd,
  output logic          impl
);
  logic [31:0] bank [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (MASK[g]) begin : g_reg
      logic [31:0] r;
      always_ff @(posedge clk) begin
        if (!rst_n) r <= '0;
        else if (we && slot == SW'(g)) r <= wd;
      end
      assign bank[g] = r;
    end else begin : g_hole
      assign bank[g] = '1;
    end
  end

  assign rd   = bank[slot];
  assign impl = MASK[slot];
endmodule

// File: rtl/mmw_decoder.sv
module mmw_decoder
  import mmw_pkg::*;
#(
  parameter logic [31:0] STREAM_MASK = 32'hFFFF_0173,
  parameter int          VGA_N       = 48,
  parameter int          ACC_BYTES   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accel_en,
  input  logic        enh_mode,
  input  logic        cpu_src,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic [15:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic [7:0]  stat_set,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        pix_start,
  output logic [31:0] pix_data,
  output logic [7:0]  adv_ctl,
  output logic        irq
);
  localparam logic [8:0]  STREAM_PAGE = 9'h103;   // 0x8180..0x81FF
  localparam logic [13:0] SUBSYS_DW   = 14'h2141; // 0x8504 >> 2

  // named internal events
  logic go, hit_pix, hit_stream, w1c_hit, lane_path, stream_impl;
  logic [15:0]         base_addr;
  logic [NL-1:0]       lmask;
  lane_t [NL-1:0]      lanes;
  logic [NL-1:0][7:0]  lane_rd;
  logic [31:0]         lane_bytes, stream_rd, rd_next;
  logic [7:0]          ctl_w, stat_w;

  assign go         = req_valid & accel_en;
  assign hit_pix    = go & ~req_addr[15];
  assign hit_stream = go & enh_mode & (req_size == SZ_D) &
                      (req_addr[15:7] == STREAM_PAGE) & stream_impl;
  assign w1c_hit    = go & enh_mode & req_write & (req_size == SZ_D) &
                      (req_addr[15:2] == SUBSYS_DW);
  assign lane_path  = go & req_addr[15] & ~hit_stream & ~w1c_hit;
  assign base_addr  = align_base(req_addr, req_size);
  assign lmask      = lane_mask(req_size);

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [15:0] ba;
    tgt_e        t;
    logic [5:0]  ix;
    assign ba = base_addr + 16'(g);
    mmw_lane_dec #(.ACC_BYTES(ACC_BYTES)) u_dec (
      .baddr(ba), .enh(enh_mode), .tgt(t), .idx(ix)
    );
    assign lanes[g] = '{act: lane_path & lmask[g], tgt: t, idx: ix,
                        wd: req_wdata[8*g +: 8]};
    assign lane_bytes[8*g +: 8] = lanes[g].act ? lane_rd[g] : 8'hFF;
  end

  mmw_byte_regs #(.VGA_N(VGA_N), .ACC_N(ACC_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n), .lanes(lanes), .lanes_we(req_write),
    .w1c_en(w1c_hit), .w1c_mask(req_wdata[7:0]), .ctl_load(req_wdata[15:8]),
    .stat_set(stat_set), .lane_rd(lane_rd), .ctl_q(ctl_w), .stat_q(stat_w),
    .adv_q(adv_ctl), .irq_q(irq)
  );

  mmw_stream_bank #(.SLOTS(32), .MASK(STREAM_MASK)) u_stream (
    .clk(clk), .rst_n(rst_n), .we(hit_stream & req_write),
    .slot(req_addr[6:2]), .wd(req_wdata), .rd(stream_rd), .impl(stream_impl)
  );

  always_comb begin
    if (!go || !req_addr[15]) rd_next = '1;
    else if (hit_stream)      rd_next = stream_rd;
    else                      rd_next = lane_bytes;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      pix_start <= 1'b0;
      pix_data  <= '0;
    end else begin
      rd_valid  <= req_valid & ~req_write;
      if (req_valid && !req_write) rd_data <= rd_next;
      pix_start <= hit_pix & req_write & cpu_src;
      if (hit_pix && req_write && cpu_src) pix_data <= spread(req_wdata, req_size);
    end
  end
endmodule

// File: rtl/mmw_decoder_chk.sv
module mmw_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        accel_en,
  input logic        cpu_src,
  input logic        req_valid,
  input logic        req_write,
  input logic [1:0]  req_size,
  input logic [15:0] req_addr,
  input logic [31:0] req_wdata,
  input logic        rd_valid,
  input logic [31:0] rd_data,
  input logic        pix_start,
  input logic [31:0] pix_data,
  input logic [7:0]  adv_ctl,
  input logic        irq,
  input logic [7:0]  stat_w,
  input logic [7:0]  ctl_w
);
  logic pix_wr;
  assign pix_wr = req_valid & req_write & accel_en & cpu_src & ~req_addr[15];

  assert_pix_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pix_start |-> $past(pix_wr));

  assert_byte_spread_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_wr && req_size == 2'd0) |=> pix_data == {4{$past(req_wdata[7:0])}});

  assert_rd_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid & ~req_write));

  assert_off_read_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid & ~req_write & ~accel_en) |=> rd_data == 32'hFFFF_FFFF);

  assert_off_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid & req_write & ~accel_en) |=> $stable(adv_ctl));

  assert_irq_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(stat_w & ctl_w));
endmodule

bind mmw_decoder mmw_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .accel_en(accel_en), .cpu_src(cpu_src),
  .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
  .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
  .rd_data(rd_data), .pix_start(pix_start), .pix_data(pix_data),
  .adv_ctl(adv_ctl), .irq(irq), .stat_w(stat_w), .ctl_w(ctl_w)
);

// File: tb/mmw_decoder_test.sv
module mmw_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        accel_en = 1'b1, enh_mode = 1'b1, cpu_src = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [7:0]  stat_set = '0;
  logic        rd_valid, pix_start, irq;
  logic [31:0] rd_data, pix_data;
  logic [7:0]  adv_ctl;

  int tests = 0, fails = 0;

  always #4 clk = ~clk;  // 125 MHz

  mmw_decoder uut (.*);

  typedef struct packed {
    logic enh; logic wr; logic [1:0] sz; logic [15:0] addr;
    logic [31:0] data; logic [31:0] exp; logic [3:0] rq;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VT [NV] = '{
    '{1'b1, 1'b1, 2'd2, 16'h83C0, 32'h44332211, 32'h0,        4'd5 },  // R5
    '{1'b1, 1'b0, 2'd0, 16'h83C2, 32'h0,        32'hFFFFFF33, 4'd5 },  // R5 R12
    '{1'b1, 1'b0, 2'd1, 16'h83C1, 32'h0,        32'hFFFF2211, 4'd14},  // R14
    '{1'b1, 1'b0, 2'd2, 16'h83C3, 32'h0,        32'h44332211, 4'd14},  // R14
    '{1'b1, 1'b1, 2'd0, 16'h8505, 32'hA5,       32'h0,        4'd6 },  // R6
    '{1'b1, 1'b0, 2'd0, 16'h8505, 32'h0,        32'hFFFFFFA5, 4'd6 },  // R6
    '{1'b1, 1'b1, 2'd0, 16'h8504, 32'hFF,       32'h0,        4'd6 },  // R6
    '{1'b1, 1'b0, 2'd0, 16'h8504, 32'h0,        32'hFFFFFF00, 4'd6 },  // R6
    '{1'b1, 1'b0, 2'd2, 16'h8504, 32'h0,        32'hFFFFA500, 4'd6 },  // R6
    '{1'b1, 1'b1, 2'd2, 16'h8180, 32'hDEADBEEF, 32'h0,        4'd10},  // R10
    '{1'b1, 1'b0, 2'd2, 16'h8180, 32'h0,        32'hDEADBEEF, 4'd10},  // R10
    '{1'b1, 1'b1, 2'd2, 16'h81FC, 32'h12345678, 32'h0,        4'd10},  // R10
    '{1'b1, 1'b0, 2'd2, 16'h81FC, 32'h0,        32'h12345678, 4'd10},  // R10
    '{1'b1, 1'b1, 2'd2, 16'h8188, 32'hCAFEF00D, 32'h0,        4'd10},  // R10 hole
    '{1'b1, 1'b0, 2'd2, 16'h8188, 32'h0,        32'hFFFFFFFF, 4'd10},  // R10
    '{1'b1, 1'b0, 2'd0, 16'h8180, 32'h0,        32'hFFFFFFFF, 4'd10},  // R10
    '{1'b1, 1'b0, 2'd2, 16'h9000, 32'h0,        32'hFFFFFFFF, 4'd12},  // R12
    '{1'b1, 1'b1, 2'd2, 16'h8000, 32'h0F0E0D0C, 32'h0,        4'd11},  // R11
    '{1'b0, 1'b0, 2'd2, 16'h8000, 32'h0,        32'h0F0E0D0C, 4'd11},  // R11
    '{1'b0, 1'b0, 2'd0, 16'h8505, 32'h0,        32'hFFFFFFFF, 4'd11},  // R11
    '{1'b0, 1'b1, 2'd0, 16'h83C0, 32'h77,       32'h0,        4'd11},  // R11
    '{1'b1, 1'b0, 2'd0, 16'h83C0, 32'h0,        32'hFFFFFF11, 4'd11},  // R11
    '{1'b1, 1'b1, 2'd0, 16'h850C, 32'h3C,       32'h0,        4'd9 },  // R9
    '{1'b1, 1'b0, 2'd0, 16'h850C, 32'h0,        32'hFFFFFFFF, 4'd9 },  // R9
    '{1'b1, 1'b0, 2'd0, 16'h0100, 32'h0,        32'hFFFFFFFF, 4'd3 },  // R3
    '{1'b0, 1'b1, 2'd2, 16'h8184, 32'h11111111, 32'h0,        4'd11},  // R11
    '{1'b1, 1'b0, 2'd2, 16'h8184, 32'h0,        32'h00000000, 4'd11}   // R11
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic req(input logic enh, input logic wr, input logic [1:0] sz,
                     input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    enh_mode = enh; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rd_valid", 32'(rd_valid), 32'd0);
    chk("R1 pix_start", 32'(pix_start), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 adv_ctl", 32'(adv_ctl), 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      req(VT[i].enh, VT[i].wr, VT[i].sz, VT[i].addr, VT[i].data);
      if (VT[i].wr) chk("R2 no strobe on write", 32'(rd_valid), 32'd0);
      else begin
        chk("R2 strobe", 32'(rd_valid), 32'd1);
        chk($sformatf("R%0d vector %0d", VT[i].rq, i), rd_data, VT[i].exp);
      end
    end
    @(negedge clk);
    chk("R2 strobe one cycle", 32'(rd_valid), 32'd0);
    chk("R9 adv_ctl", 32'(adv_ctl), 32'h3C);

    // pixel port R3 R4
    cpu_src = 1'b1;
    req(1'b1, 1'b1, 2'd0, 16'h0010, 32'h000000AB);
    chk("R3 pulse", 32'(pix_start), 32'd1);
    chk("R4 byte", pix_data, 32'hABABABAB);
    @(negedge clk);
    chk("R3 single pulse", 32'(pix_start), 32'd0);
    req(1'b1, 1'b1, 2'd1, 16'h7FFE, 32'h00001234);
    chk("R4 word", pix_data, 32'h12341234);
    req(1'b1, 1'b1, 2'd2, 16'h0004, 32'h89ABCDEF);
    chk("R4 dword", pix_data, 32'h89ABCDEF);
    req(1'b0, 1'b1, 2'd0, 16'h0000, 32'h0000005A);
    chk("R11 legacy pixel", pix_data, 32'h5A5A5A5A);
    cpu_src = 1'b0;
    req(1'b1, 1'b1, 2'd0, 16'h0020, 32'h00000011);
    chk("R3 no cpu source", 32'(pix_start), 32'd0);
    cpu_src = 1'b1;

    // status / irq R7 R8 (control = 0xA5)
    @(negedge clk); stat_set = 8'h01;
    @(negedge clk); stat_set = 8'h00;
    chk("R8 irq set", 32'(irq), 32'd1);
    req(1'b1, 1'b0, 2'd0, 16'h8504, 32'h0);
    chk("R7 status", rd_data, 32'hFFFFFF01);
    req(1'b1, 1'b1, 2'd2, 16'h8504, 32'h00005A01);
    chk("R8 irq clear", 32'(irq), 32'd0);
    req(1'b1, 1'b0, 2'd0, 16'h8505, 32'h0);
    chk("R7 control load", rd_data, 32'hFFFFFF5A);
    @(negedge clk);
    stat_set = 8'h02; enh_mode = 1'b1; req_write = 1'b1; req_size = 2'd2;
    req_addr = 16'h8504; req_wdata = 32'h00005A02; req_valid = 1'b1;
    @(negedge clk);
    stat_set = 8'h00; req_valid = 1'b0;
    chk("R8 irq set wins", 32'(irq), 32'd1);
    req(1'b1, 1'b0, 2'd0, 16'h8504, 32'h0);
    chk("R7 set wins", rd_data, 32'hFFFFFF02);
    req(1'b1, 1'b1, 2'd1, 16'h8504, 32'h00003300);
    req(1'b1, 1'b0, 2'd2, 16'h8504, 32'h0);
    chk("R6 word split", rd_data, 32'hFFFF3302);

    // disabled window R13
    accel_en = 1'b0;
    req(1'b1, 1'b0, 2'd0, 16'h8505, 32'h0);
    chk("R13 read ones", rd_data, 32'hFFFFFFFF);
    req(1'b1, 1'b1, 2'd0, 16'h8505, 32'h00000000);
    req(1'b1, 1'b1, 2'd0, 16'h850C, 32'h00000099);
    req(1'b1, 1'b1, 2'd0, 16'h0000, 32'h00000044);
    chk("R13 no pulse", 32'(pix_start), 32'd0);
    accel_en = 1'b1;
    req(1'b1, 1'b0, 2'd0, 16'h8505, 32'h0);
    chk("R13 control kept", rd_data, 32'hFFFFFF33);
    chk("R13 adv kept", 32'(adv_ctl), 32'h3C);
    req(1'b1, 1'b0, 2'd1, 16'h9002, 32'h0);
    chk("R12 word unmapped", rd_data, 32'hFFFFFFFF);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule